// File: doc/BRIEF.md
# Processor Clock Throttling Controller

This block slows a processor without touching its supply voltage. It holds a 32-bit control word and drives an active-low stop-clock line, `stpclk_n`, toward the processor. Inside the word sit a duty field and an enable bit. While throttling is enabled, the processor is allowed to run for only part of each throttle period. The duty field's bit offset and width are fixed at elaboration. Its width sets both the period length and the resolution of the duty setting.

Software changes the duty setting in three steps: clear the enable bit, write the new duty value, then set the enable bit again. The block copies the duty field into a working latch only at the moment the enable bit goes from 0 to 1. A duty value written while throttling stays enabled is stored and reads back, but the waveform ignores it until the next re-enable.

The waveform comes from a three-state machine that runs alongside a period counter. The states are `ST_OFF`, `ST_RUN` and `ST_STOP`:
- **ST_OFF** is the state while throttling is disabled; the clock is allowed.
- **ST_RUN** allows the clock during the active part of the period.
- **ST_STOP** asserts stop-clock during the rest of the period.

The transitions are:
- **enable rise**: any state to `ST_RUN`. The counter goes to 0 and the duty latch is loaded.
- **enable fall**: any state to `ST_OFF`.
- **duty reached**: `ST_RUN` to `ST_STOP`, when the counter is on the last active tick.
- **period wrap**: `ST_STOP` to `ST_RUN`, when the counter is on its last tick.

Top module: `cpu_throttle_ctrl`

## Requirements
- R1: Reset clears the whole control word to 0, and `stpclk_n` is 1 during and after reset.
- R2: A write with `reg_we` high stores all 32 bits of `reg_wdata`, and `reg_rdata` returns them from the next cycle on. All bits are kept, including those outside the duty field and the enable bit. Without a write, the word does not change.
- R3: The duty field occupies bits `DUTY_OFS` to `DUTY_OFS+DUTY_W-1`. Elaboration stops with an error if that top bit is above 31, or if the field covers bit 4.
- R4: The enable bit is bit 4. While it is 0, `stpclk_n` stays 1 whatever the duty field holds.
- R5: The throttle period is P = 2^`DUTY_W` clock cycles. With the enable bit set and a latched duty value N in 1..P-1, `stpclk_n` is 1 for counter ticks 0..N-1 and 0 for ticks N..P-1 of every period. Tick 0 is the cycle after the enabling write.
- R6: A latched duty value of 0 means full speed: `stpclk_n` never goes to 0.
- R7: A write that changes the duty field while the enable bit stays 1 does not change the waveform: phase and duty continue unchanged.
- R8: A write that clears the enable bit makes `stpclk_n` 1 from the next cycle on.
- R9: A write that sets the enable bit from 0 restarts the period at tick 0 and latches the duty field from that same write.
- R10: With `DUTY_W` = 0, throttling is unsupported and `stpclk_n` is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period-counter tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data for the control word |
| reg_rdata | output | 32 | Read-back of the stored control word |
| stpclk_n | output | 1 | Stop-clock to the processor, 0 = stop |

## Verification
On every cycle, assertions check the local rules:
- the line stays high while disabled and is released after a disable;
- the counter restarts on a rising enable and advances by one while enabled;
- the duty latch does not move while throttling stays on;
- a zero latch never stops the clock;
- a low output only appears on ticks at or past the latched duty;
- read-back follows each write and holds otherwise.

Only the bench scenarios show the exact high/low pattern over whole periods for several duty values. They also show:
- that a mid-run duty write takes effect only after a disable and re-enable;
- that a width-0 instance never throttles.

The bench compares each cycle against its own model of the register and the period.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int CTRL_W     = 32;
    localparam int ENABLE_BIT = 4;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } thr_state_e;
endpackage

// File: rtl/thr_ctrl_reg.sv
module thr_ctrl_reg
    import thr_pkg::*;
#(
    parameter int FIELD_OFS = 1,
    parameter int FIELD_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [CTRL_W-1:0]   wdata,
    output logic [CTRL_W-1:0]   rdata,
    output logic                en_q,
    output logic                en_d,
    output logic [FIELD_W-1:0]  field_d
);
    logic [CTRL_W-1:0] word_q;
    logic [CTRL_W-1:0] word_d;

    always_comb begin
        word_d = we ? wdata : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign rdata   = word_q;
    assign en_q    = word_q[ENABLE_BIT];
    assign en_d    = word_d[ENABLE_BIT];
    assign field_d = word_d[FIELD_OFS +: FIELD_W];

    // R2: a write is visible on the next cycle
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we)) |-> (rdata == $past(wdata)))
        else $error("R2 read-back mismatch");

    // R2: no write, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(we)) |-> $stable(rdata))
        else $error("R2 word changed without write");
endmodule

// File: rtl/thr_period_fsm.sv
module thr_period_fsm
    import thr_pkg::*;
#(
    parameter int FIELD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_q,
    input  logic               en_d,
    input  logic [FIELD_W-1:0] field_d,
    output logic               stpclk_n
);
    localparam logic [FIELD_W-1:0] CNT_LAST = '1;
    localparam logic [FIELD_W-1:0] ONE      = FIELD_W'(1);

    thr_state_e         state_q, state_d;
    logic [FIELD_W-1:0] cnt_q, cnt_d;
    logic [FIELD_W-1:0] lat_q, lat_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + ONE;
        lat_d   = lat_q;
        if (!en_d) begin
            state_d = ST_OFF;            // enable fall
            cnt_d   = '0;
        end else if (!en_q) begin
            state_d = ST_RUN;            // enable rise
            cnt_d   = '0;
            lat_d   = field_d;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_RUN;
                ST_RUN:  if (lat_q != '0 && cnt_q == lat_q - ONE)
                             state_d = ST_STOP;   // duty reached
                ST_STOP: if (cnt_q == CNT_LAST)
                             state_d = ST_RUN;    // period wrap
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            lat_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lat_q   <= lat_d;
        end
    end

    always_comb begin
        stpclk_n = (state_q != ST_STOP);
    end

    p_off_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> stpclk_n) else $error("R4 stop while disabled");

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |-> stpclk_n) else $error("R8 not released");

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> (cnt_q == '0 && stpclk_n)) else $error("R9 no restart");

    p_hold_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q)) |-> $stable(lat_q)) else $error("R7 latch moved");

    p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q)) |-> (cnt_q == $past(cnt_q) + ONE))
        else $error("R5 counter step");

    p_stop_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !stpclk_n |-> (lat_q != '0 && cnt_q >= lat_q))
        else $error("R5 stop outside window");

    p_zero_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && lat_q == '0) |-> stpclk_n) else $error("R6 zero duty stopped");
endmodule

// File: rtl/cpu_throttle_ctrl.sv
module cpu_throttle_ctrl
    import thr_pkg::*;
#(
    parameter int DUTY_OFS = 1,
    parameter int DUTY_W   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        stpclk_n
);
    localparam int  FW        = (DUTY_W == 0) ? 1 : DUTY_W;
    localparam int  OFS_USED  = (DUTY_W == 0) ? 0 : DUTY_OFS;
    localparam int  FIELD_TOP = DUTY_OFS + DUTY_W - 1;
    localparam bit  FIELD_OK  = (DUTY_W == 0) ||
                                ((FIELD_TOP <= CTRL_W - 1) &&
                                 !(DUTY_OFS <= ENABLE_BIT && FIELD_TOP >= ENABLE_BIT));

    // R3: illegal duty-field placement stops elaboration
    if (!FIELD_OK) begin : g_bad_field
        $error("duty field overflows the word or covers the enable bit");
    end

    logic          en_q, en_d;
    logic [FW-1:0] field_d;

    thr_ctrl_reg #(.FIELD_OFS(OFS_USED), .FIELD_W(FW)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .en_q   (en_q),
        .en_d   (en_d),
        .field_d(field_d)
    );

    if (DUTY_W == 0) begin : g_no_throttle
        // R10: no duty field, clock never stopped
        assign stpclk_n = 1'b1;
    end else begin : g_throttle
        thr_period_fsm #(.FIELD_W(FW)) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_q    (en_q),
            .en_d    (en_d),
            .field_d (field_d),
            .stpclk_n(stpclk_n)
        );
    end
endmodule

// File: tb/cpu_throttle_ctrl_tb.sv
module cpu_throttle_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int OFS = 1;
    localparam int W   = 3;
    localparam int PER = 1 << W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, nt_rdata;
    logic        stpclk_n, nt_stpclk_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        exp_stp_q[$];
    logic [31:0] exp_rd_q[$];
    string       tag_q[$];

    logic [31:0] m_reg = '0;
    bit          m_en = 1'b0;
    int          m_lat = 0;
    int          m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_throttle_ctrl #(.DUTY_OFS(OFS), .DUTY_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .stpclk_n(stpclk_n));

    cpu_throttle_ctrl #(.DUTY_OFS(0), .DUTY_W(0)) u_nothr (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(nt_rdata), .stpclk_n(nt_stpclk_n));

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: one clock cycle, optional write, expected result pushed
    task automatic cyc(bit w, logic [31:0] d, string tag);
        logic [31:0] nr;
        reg_we = w;
        reg_wdata = d;
        @(posedge clk);
        nr = w ? d : m_reg;
        if (!nr[4])     m_cnt = 0;
        else if (!m_en) begin m_lat = int'((nr >> OFS) & (PER - 1)); m_cnt = 0; end
        else            m_cnt = (m_cnt + 1) % PER;
        m_en  = nr[4];
        m_reg = nr;
        exp_stp_q.push_back(!m_en || m_lat == 0 || m_cnt < m_lat);
        exp_rd_q.push_back(m_reg);
        tag_q.push_back(tag);
        #1 reg_we = 1'b0;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, tag);
    endtask

    // monitor: pops and compares away from the active edge
    always @(negedge clk) begin
        if (exp_stp_q.size() > 0) begin
            logic        es;
            logic [31:0] er;
            string       t;
            es = exp_stp_q.pop_front();
            er = exp_rd_q.pop_front();
            t  = tag_q.pop_front();
            check({t, " stpclk_n"}, {31'b0, stpclk_n}, {31'b0, es});
            check("R2 rdata", reg_rdata, er);
            check("R10 width0 stpclk_n", {31'b0, nt_stpclk_n}, 32'd1);
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        reg_we = 1'b1;
        reg_wdata = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R1 reset rdata", reg_rdata, 32'h0);
        check("R1 reset stpclk_n", {31'b0, stpclk_n}, 32'd1);
        reg_we = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        idle(3, "R1");

        // disabled, nonzero duty, upper bits set
        cyc(1'b1, 32'hA5A5_0006, "R4");
        idle(10, "R4");
        // enable with duty 3
        cyc(1'b1, 32'hA5A5_0016, "R5 R9");
        idle(20, "R5");
        // change duty to 5 with enable held: no effect
        cyc(1'b1, 32'hA5A5_001A, "R7");
        idle(20, "R7");
        // disable at a stop tick
        idle(2, "R5");
        cyc(1'b1, 32'hA5A5_000A, "R8");
        idle(5, "R8");
        // re-enable: duty 5 now applies
        cyc(1'b1, 32'hA5A5_001A, "R9");
        idle(16, "R5");
        // back-to-back disable and re-enable with duty 1
        idle(3, "R5");
        cyc(1'b1, 32'h0000_0002, "R8");
        cyc(1'b1, 32'h0000_0012, "R9");
        idle(16, "R5");
        // duty 0 means full speed
        cyc(1'b1, 32'h0000_0000, "R8");
        cyc(1'b1, 32'h0000_0010, "R6");
        idle(16, "R6");
        // maximum representable duty 7
        cyc(1'b1, 32'h0000_000E, "R8");
        cyc(1'b1, 32'h0000_001E, "R5");
        idle(16, "R5");
        // all bits outside the enable bit, disabled
        cyc(1'b1, 32'hFFFF_FFEF, "R2 R4");
        idle(10, "R4");
        // enable with every other bit set: duty 7
        cyc(1'b1, 32'hFFFF_FFFF, "R5");
        idle(12, "R5");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule